// File: doc/BRIEF.md
# Hierarchical Carry Look-Ahead Adder

This block adds two unsigned operands and a carry-in with no clock and no state. Each bit position first reports whether it would create a carry (both operand bits set) or pass an incoming carry along (exactly one operand bit set). A balanced binary tree of two-input merge cells folds these per-bit terms into terms for bit pairs, then for groups of four, then for the whole word. Walking the same tree from the root back down gives the carry into every bit position. The worst-case carry path therefore grows with the logarithm of the width, not with the width itself.

The root of the tree also leaves the block as a word-level "propagates" flag and a word-level "generates" flag. A second look-ahead level above several of these units can use the two flags to compute each unit's carry-in directly, without any rippling between units. The width is a power-of-two parameter, 8 by default.

Top module: `lookahead_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of opA + opB + carryIn for every input combination.
- R2: `carryOut` equals bit WIDTH of opA + opB + carryIn for every input combination.
- R3: `groupProp` is 1 exactly when opA XOR opB has all bits set, whatever the value of carryIn.
- R4: `groupGen` is 1 exactly when opA + opB, with carryIn not added, is at least 2^WIDTH, whatever the value of carryIn.
- R5: `carryOut` equals groupGen OR (groupProp AND carryIn), so a higher look-ahead level can rebuild the unit's carry from the two exported flags.
- R6: `groupProp` and `groupGen` are never both 1.
- R7: The block holds no state: all outputs follow a change on the inputs within the same clock period, with no clock edge in between.
- R8: A carry that enters at carryIn and passes through every bit gives the correct result: opA = all ones, opB = 0, carryIn = 1 gives sum = 0, carryOut = 1, groupProp = 1, groupGen = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carryOut | output | 1 | Carry out of the top bit |
| groupProp | output | 1 | The whole word passes an incoming carry along |
| groupGen | output | 1 | The whole word creates a carry by itself |

## Verification
Because the block has no state, a wrong node in the merge tree or in the carry split shows up at once, in the same period in which the inputs that reach that node are applied. A wrong merge at a low level corrupts the carry into the bits above it, and so the sum and carryOut, only for operand patterns that route a carry through that node. For this reason all 2^17 combinations of the default width are applied, one per clock, and checked against an arithmetic reference. A fault that touches only the exported flags is found by checking them separately against their XOR-all-ones and overflow-without-carry definitions.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;

  // Propagate / generate pair carried through the merge tree.
  typedef struct packed {
    logic prop;
    logic gen;
  } pgPair_t;

  // First node index of tree level k, where level 0 holds the bit terms.
  function automatic int levelBase(input int width, input int k);
    return 2 * width - ((2 * width) >> k);
  endfunction

endpackage

// File: rtl/bit_pg_cell.sv
module bit_pg_cell
  import lookahead_pkg::*;
(
  input  logic    aBit,
  input  logic    bBit,
  output pgPair_t bitPg
);

  always_comb begin
    bitPg.prop = aBit ^ bBit;
    bitPg.gen  = aBit & bBit;
  end

  // R6: a single bit cannot both pass and create a carry
  always_comb begin
    assert_bit_exclusive_R6: assert (!(bitPg.prop && bitPg.gen))
      else $error("bit cell reports both prop and gen");
  end

endmodule

// File: rtl/pg_merge_cell.sv
module pg_merge_cell
  import lookahead_pkg::*;
(
  input  pgPair_t loPg,
  input  pgPair_t hiPg,
  output pgPair_t outPg
);

  always_comb begin
    outPg.prop = loPg.prop & hiPg.prop;
    outPg.gen  = hiPg.gen | (hiPg.prop & loPg.gen);
  end

  // R6: exclusive children must give an exclusive parent
  always_comb begin
    if (!(loPg.prop && loPg.gen) && !(hiPg.prop && hiPg.gen)) begin
      assert_merge_exclusive_R6: assert (!(outPg.prop && outPg.gen))
        else $error("merged group reports both prop and gen");
    end
  end

endmodule

// File: rtl/carry_split_cell.sv
module carry_split_cell
  import lookahead_pkg::*;
(
  input  logic    parentCarry,
  input  pgPair_t loPg,
  output logic    loCarry,
  output logic    hiCarry
);

  always_comb begin
    loCarry = parentCarry;
    hiCarry = loPg.gen | (loPg.prop & parentCarry);
  end

  // R5: the low half's group terms decide the carry into the high half
  always_comb begin
    if (loPg.gen) begin
      assert_split_gen_R5: assert (hiCarry)
        else $error("generating low half did not carry");
    end
    if (!loPg.gen && !loPg.prop) begin
      assert_split_kill_R5: assert (!hiCarry)
        else $error("killing low half passed a carry");
    end
  end

endmodule

// File: rtl/pg_tree.sv
module pg_tree
  import lookahead_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  pgPair_t [WIDTH-1:0] bitPg,
  input  logic                carryIn,
  output logic    [WIDTH-1:0] bitCarry,
  output pgPair_t             topPg
);

  localparam int LEVELS = $clog2(WIDTH);
  localparam int NODES  = 2 * WIDTH - 1;
  localparam int ROOT   = NODES - 1;

  pgPair_t [NODES-1:0] nodePg;
  logic    [NODES-1:0] nodeCarry;

  for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
    assign nodePg[i]   = bitPg[i];
    assign bitCarry[i] = nodeCarry[i];
  end

  for (genvar k = 1; k <= LEVELS; k++) begin : g_level
    for (genvar j = 0; j < (WIDTH >> k); j++) begin : g_node
      localparam int PARENT = levelBase(WIDTH, k) + j;
      localparam int LO     = levelBase(WIDTH, k - 1) + 2 * j;
      localparam int HI     = LO + 1;

      pg_merge_cell u_merge (
        .loPg (nodePg[LO]),
        .hiPg (nodePg[HI]),
        .outPg(nodePg[PARENT])
      );

      carry_split_cell u_split (
        .parentCarry(nodeCarry[PARENT]),
        .loPg       (nodePg[LO]),
        .loCarry    (nodeCarry[LO]),
        .hiCarry    (nodeCarry[HI])
      );
    end
  end

  assign nodeCarry[ROOT] = carryIn;
  assign topPg           = nodePg[ROOT];

  // R7: the carry into bit 0 is the block carry-in, with no state between
  always_comb begin
    assert_bit0_carry_R7: assert (bitCarry[0] == carryIn)
      else $error("carry into bit 0 differs from carry-in");
  end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import lookahead_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             groupProp,
  output logic             groupGen
);

  pgPair_t [WIDTH-1:0] bitPg;
  logic    [WIDTH-1:0] bitCarry;
  pgPair_t             topPg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    bit_pg_cell u_cell (
      .aBit (opA[i]),
      .bBit (opB[i]),
      .bitPg(bitPg[i])
    );
    assign sum[i] = bitPg[i].prop ^ bitCarry[i];
  end

  pg_tree #(.WIDTH(WIDTH)) u_tree (
    .bitPg   (bitPg),
    .carryIn (carryIn),
    .bitCarry(bitCarry),
    .topPg   (topPg)
  );

  assign groupProp = topPg.prop;
  assign groupGen  = topPg.gen;
  assign carryOut  = topPg.gen | (topPg.prop & carryIn);

  // Arithmetic reference used only by the assertions below.
  logic [WIDTH:0] refTotal;
  logic [WIDTH:0] refNoCin;
  assign refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
  assign refNoCin = {1'b0, opA} + {1'b0, opB};

  always_comb begin
    assert_sum_R1: assert (sum == refTotal[WIDTH-1:0])
      else $error("sum differs from arithmetic total");
    assert_carry_out_R2: assert (carryOut == refTotal[WIDTH])
      else $error("carry-out differs from arithmetic total");
    assert_group_prop_R3: assert (groupProp == (&(opA ^ opB)))
      else $error("group propagate wrong");
    assert_group_gen_R4: assert (groupGen == refNoCin[WIDTH])
      else $error("group generate wrong");
  end

endmodule

// File: tb/sim_lookahead_adder.sv
module sim_lookahead_adder;

  localparam int W = 8;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sum;
  logic         carryOut, groupProp, groupGen;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  lookahead_adder #(.WIDTH(W)) u0 (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sum), .carryOut(carryOut),
    .groupProp(groupProp), .groupGen(groupGen)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (a=%0d b=%0d cin=%0d)",
               req, what, actual, expected, opA, opB, carryIn);
    end
  endtask

  // Behavioural reference: integer arithmetic only.
  task automatic checkAll();
    int a, b, c, total, noCin, expP, expG;
    a = int'(opA); b = int'(opB); c = int'(carryIn);
    total = a + b + c;
    noCin = a + b;
    expP  = ((a ^ b) == (1 << W) - 1) ? 1 : 0;
    expG  = (noCin >= (1 << W)) ? 1 : 0;
    check("R1", "sum",       int'(sum),       total % (1 << W));
    check("R2", "carryOut",  int'(carryOut),  total / (1 << W));
    check("R3", "groupProp", int'(groupProp), expP);
    check("R4", "groupGen",  int'(groupGen),  expG);
    check("R5", "cascade",   int'(carryOut),  (expG != 0 || (expP != 0 && c != 0)) ? 1 : 0);
    check("R6", "exclusive", int'(groupProp && groupGen), 0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    // Reset phase: zero inputs must give zero outputs (R1, R4).
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "reset sum", int'(sum), 0);
    check("R4", "reset gen", int'(groupGen), 0);
    rstN = 1'b1;

    // R8: carry entering at bit 0 passes through every bit.
    @(posedge clk);
    opA = '1; opB = '0; carryIn = 1'b1;
    @(negedge clk);
    check("R8", "sum",  int'(sum), 0);
    check("R8", "cout", int'(carryOut), 1);
    check("R8", "P",    int'(groupProp), 1);
    check("R8", "G",    int'(groupGen), 0);

    // R7: outputs follow input changes with no clock edge between.
    opA = 8'd100; opB = 8'd27; carryIn = 1'b0;
    #1;
    check("R7", "same-period sum", int'(sum), 127);
    opA = 8'd200; opB = 8'd100; carryIn = 1'b1;
    #1;
    check("R7", "same-period sum", int'(sum), 301 % 256);
    check("R7", "same-period cout", int'(carryOut), 1);

    // Exhaustive sweep, one vector per clock, checked mid-period.
    for (int v = 0; v < (1 << (2 * W + 1)); v++) begin
      @(posedge clk);
      #1;
      {carryIn, opB, opA} = v[2*W:0];
      @(negedge clk);
      checkAll();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule